// File: doc/BRIEF.md
# Block-Write Configuration Slave for a Clock Generator

This block is a two-wire serial bus slave that lets a system controller program a small bank of 8-bit control registers inside a clock generator. The slave accepts block-write transactions only. Each one carries a fixed address byte, then a command byte and a byte count, and then the data bytes. The command byte and the count byte are required on the wire but are not stored. The data bytes land in the register bank in strict ascending order, starting at register 0. There is no indexed access. The master may end a transfer after any complete byte, and the registers written up to that point keep their new values.

Both bus lines are sampled into the system clock domain through synchronizer flops. A start or stop condition is recognised as a data-line edge while the clock line is high. The data line is open-drain: the block never drives it high and only asserts a pull-low enable during its acknowledge slot. The register bank is presented as one flat vector, byte k in bits [8k+7:8k]. The frequency-select field and the strap-override flag held in register 4 are also decoded onto separate ports for the neighbouring divider logic.

Top module: `smb_cfg_slave`

## Requirements
- R1: Out of reset, register 0 reads 0x06, register 1 reads 0xFF, register 2 reads 0xFE and every other register reads 0x00. Register k appears on `reg_o[8k+7:8k]`, and the pull-low enable is off.
- R2: The address byte 0xD2 (7-bit address 0x69 with the write bit 0) is acknowledged. Any other value, including 0xD3 (a read), gets no acknowledge. The slave then acknowledges nothing and stores nothing until the next start condition.
- R3: After a matching address, the next byte (the command code) is acknowledged whatever its value, and it changes no register.
- R4: The byte after the command code is the byte count. Values 1 to 32 are acknowledged. A value of 0 or above 32 gets no acknowledge, and the transfer is abandoned with no data stored.
- R5: Data bytes are shifted in most significant bit first and are written to registers 0, 1, 2, … in arrival order. Each one is acknowledged.
- R6: A stop condition after any complete data byte ends the transfer. Registers already written keep their new values, and the rest keep their old values.
- R7: Data bytes within the count but past the last implemented register are acknowledged and discarded.
- R8: Data bytes beyond the byte count get no acknowledge and are discarded.
- R9: `freq_sel_o` equals {register 4 bit 2, register 4 bits 7:4}, with bit 2 as the most significant select bit. `sel_override_o` equals register 4 bit 3.
- R10: The pull-low enable changes only while the clock line is low. It is asserted only in the acknowledge slot of an accepted byte and is off after a stop condition.
- R11: A start condition in the middle of a transfer abandons it and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin (wired-AND level) |
| sda_oe_o | output | 1 | Pull-low enable for the open-drain data line |
| reg_o | output | NUM_REGS*8 | Register bank, register k in bits [8k+7:8k] |
| freq_sel_o | output | 5 | Decoded frequency-select field from register 4 |
| sel_override_o | output | 1 | Strap-override flag from register 4 |

## Verification
Each bus line passes through two synchronizer flops and an edge stage before the control logic sees it. As a result, the acknowledge enable rises about three system clocks after the serial clock falls that follows the eighth bit, and a register takes its new value about four clocks after the eighth rising edge. The bench holds every serial clock phase for at least four system clocks, and it samples the acknowledge in the middle of the following high phase, well after the enable has settled. It compares the register image and the decoded select outputs only after the stop condition plus ten further clocks, so every pending write has reached the outputs by the time they are compared.

// File: rtl/smbcfg_pkg.sv
package smbcfg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_COUNT,
    PH_DATA
  } phase_t;

  // Power-on value of each control register: output enables start on,
  // reserved and select bits start off.
  function automatic logic [7:0] reg_reset_value(input int idx);
    case (idx)
      0:       return 8'h06;
      1:       return 8'hFF;
      2:       return 8'hFE;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbcfg_sync.sv
module smbcfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
  assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/smbcfg_cond.sv
module smbcfg_cond (
  input  logic scl_level,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_det,
  output logic stop_det
);
  // Data edges while the clock line is high are bus conditions.
  assign start_det = scl_level & sda_fall;
  assign stop_det  = scl_level & sda_rise;
endmodule

// File: rtl/smbcfg_fsm.sv
module smbcfg_fsm
  import smbcfg_pkg::*;
#(
  parameter logic [7:0] ADDR_BYTE = 8'hD2,
  parameter int         NUM_REGS  = 7,
  parameter int         MAX_COUNT = 32,
  localparam int        CW        = $clog2(MAX_COUNT + 1),
  localparam int        IW        = $clog2(NUM_REGS + 1),
  localparam int        IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_bit,
  input  logic             start_det,
  input  logic             stop_det,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             in_idle,
  output logic             in_data
);
  phase_t        phase, nxt_phase;
  logic [3:0]    bitcnt;     // 0..7 bits, 8 byte done, 9 ack slot
  logic [7:0]    shreg;
  logic [7:0]    byte_in;
  logic          ack_q;
  logic          accept;
  logic [CW-1:0] remain;
  logic [IW-1:0] widx;

  assign byte_in = {shreg[6:0], sda_bit};

  always_comb begin
    accept    = 1'b0;
    nxt_phase = phase;
    case (phase)
      PH_ADDR: begin
        accept    = (byte_in == ADDR_BYTE);
        nxt_phase = accept ? PH_CMD : PH_IDLE;
      end
      PH_CMD: begin
        accept    = 1'b1;
        nxt_phase = PH_COUNT;
      end
      PH_COUNT: begin
        accept    = (byte_in != 8'd0) && (byte_in <= 8'(MAX_COUNT));
        nxt_phase = accept ? PH_DATA : PH_IDLE;
      end
      PH_DATA: begin
        accept    = (remain != '0);
        nxt_phase = accept ? PH_DATA : PH_IDLE;
      end
      default: begin
        accept    = 1'b0;
        nxt_phase = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      ack_q   <= 1'b0;
      sda_oe  <= 1'b0;
      remain  <= '0;
      widx    <= '0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase  <= PH_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise && bitcnt < 4'd8) begin
          shreg <= byte_in;
          if (bitcnt == 4'd7) begin
            bitcnt <= 4'd8;
            ack_q  <= accept;
            phase  <= nxt_phase;
            if (phase == PH_COUNT && accept) begin
              remain <= byte_in[CW-1:0];
              widx   <= '0;
            end
            if (phase == PH_DATA && accept) begin
              remain <= remain - CW'(1);
              if (widx < IW'(NUM_REGS)) begin
                wr_en   <= 1'b1;
                wr_idx  <= widx[IDX_W-1:0];
                wr_data <= byte_in;
                widx    <= widx + IW'(1);
              end
            end
          end else begin
            bitcnt <= bitcnt + 4'd1;
          end
        end else if (scl_fall && bitcnt == 4'd8) begin
          sda_oe <= ack_q;
          bitcnt <= 4'd9;
        end else if (scl_fall && bitcnt == 4'd9) begin
          sda_oe <= 1'b0;
          bitcnt <= '0;
        end
      end
    end
  end

  assign in_idle = (phase == PH_IDLE);
  assign in_data = (phase == PH_DATA);
endmodule

// File: rtl/smbcfg_regbank.sv
module smbcfg_regbank
  import smbcfg_pkg::*;
#(
  parameter int  NUM_REGS = 7,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [NUM_REGS*8-1:0] regs
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g*8 +: 8] <= reg_reset_value(g);
      else if (wr_en && wr_idx == IDX_W'(g))
        regs[g*8 +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [7:0] ADDR_BYTE   = 8'hD2,
  parameter int         NUM_REGS    = 7,
  parameter int         MAX_COUNT   = 32,
  parameter int         SYNC_STAGES = 2,
  parameter int         SEL_REG     = 4,
  localparam int        IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] reg_o,
  output logic [4:0]            freq_sel_o,
  output logic                  sel_override_o
);
  logic             scl_lvl, scl_rise, scl_fall;
  logic             sda_lvl, sda_rise, sda_fall;
  logic             start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  logic             fsm_idle, fsm_data;

  smbcfg_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst(rst), .din(scl_i),
    .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
  );

  smbcfg_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst(rst), .din(sda_i),
    .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
  );

  smbcfg_cond u_cond (
    .scl_level(scl_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smbcfg_fsm #(
    .ADDR_BYTE(ADDR_BYTE), .NUM_REGS(NUM_REGS), .MAX_COUNT(MAX_COUNT)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_bit(sda_lvl),
    .start_det(start_det), .stop_det(stop_det),
    .sda_oe(sda_oe_o),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .in_idle(fsm_idle), .in_data(fsm_data)
  );

  smbcfg_regbank #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .regs(reg_o)
  );

  if (NUM_REGS > SEL_REG) begin : g_sel
    assign freq_sel_o     = {reg_o[SEL_REG*8 + 2], reg_o[SEL_REG*8 + 4 +: 4]};
    assign sel_override_o = reg_o[SEL_REG*8 + 3];
  end else begin : g_nosel
    assign freq_sel_o     = '0;
    assign sel_override_o = 1'b0;
  end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
  import smbcfg_pkg::*;
#(
  parameter int NUM_REGS = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_i,
  input logic                  sda_oe_o,
  input logic [NUM_REGS*8-1:0] reg_o,
  input logic                  fsm_idle,
  input logic                  fsm_data,
  input logic                  start_det,
  input logic                  stop_det
);
  logic [NUM_REGS*8-1:0] img;
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) img[i*8 +: 8] = reg_reset_value(i);
  end

  assert_reset_image_R1: assert property (@(posedge clk)
    rst |=> (reg_o == img && !sda_oe_o));

  assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe_o) |-> !scl_i);

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe_o);

  assert_idle_silent_R2: assert property (@(posedge clk) disable iff (rst)
    (fsm_idle && $past(fsm_idle)) |-> !sda_oe_o);

  assert_write_in_data_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_o) |-> $past(fsm_data));

  assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!fsm_idle && !sda_oe_o));
endmodule

bind smb_cfg_slave smb_cfg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe_o(sda_oe_o), .reg_o(reg_o),
  .fsm_idle(fsm_idle), .fsm_data(fsm_data),
  .start_det(start_det), .stop_det(stop_det)
);

// File: tb/smb_cfg_slave_tb_top.sv
module smb_cfg_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_REGS   = 7;
  localparam int MAX_COUNT  = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NUM_REGS*8-1:0] reg_o;
  logic [4:0] freq_sel;
  logic sel_ovr;

  assign sda_line = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_cfg_slave #(.NUM_REGS(NUM_REGS), .MAX_COUNT(MAX_COUNT)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_o(reg_o),
    .freq_sel_o(freq_sel), .sel_override_o(sel_ovr)
  );

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;
  logic [7:0] model [NUM_REGS];
  logic [7:0] tx_data [64];

  task automatic chk(input bit ok, input logic [63:0] act, input logic [63:0] exp,
                     input string msg);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(4);
    scl_m = 1'b1; wclk(4);
    sda_m = 1'b0; wclk(4);
    scl_m = 1'b0; wclk(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(4);
    scl_m = 1'b1; wclk(4);
    sda_m = 1'b1; wclk(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wclk(4);
      scl_m = 1'b1; wclk(8);
      scl_m = 1'b0; wclk(4);
    end
    sda_m = 1'b1; wclk(4);
    scl_m = 1'b1; wclk(4);
    ack = ~sda_line;
    wclk(4);
    scl_m = 1'b0; wclk(4);
  endtask

  function automatic logic [NUM_REGS*8-1:0] model_image();
    logic [NUM_REGS*8-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic check_regs(input string tag);
    logic [4:0] es;
    es = {model[4][2], model[4][7:4]};
    chk(reg_o == model_image(), 64'(reg_o), 64'(model_image()), {tag, " register image"});
    chk(freq_sel == es && sel_ovr == model[4][3], {58'd0, sel_ovr, freq_sel},
        {58'd0, model[4][3], es}, "R9 select decode");
    chk(sda_oe == 1'b0, 64'(sda_oe), 64'd0, "R10 line released after stop");
  endtask

  // One transaction: address, command, count, then nsend data bytes.
  task automatic xfer(input logic [7:0] addr_b, input logic [7:0] cmd_b,
                      input logic [7:0] cnt_b, input int nsend, input bit do_stop,
                      input string tag);
    bit ack, alive, exp;
    string t;
    bus_start();
    send_byte(addr_b, ack);
    alive = (addr_b == 8'hD2);
    chk(ack == alive, 64'(ack), 64'(alive), {tag, " R2 address ack"});
    send_byte(cmd_b, ack);
    chk(ack == alive, 64'(ack), 64'(alive), {tag, " R3 command ack"});
    send_byte(cnt_b, ack);
    exp = alive && cnt_b != 0 && cnt_b <= MAX_COUNT;
    chk(ack == exp, 64'(ack), 64'(exp), {tag, " R4 count ack"});
    alive = exp;
    for (int k = 0; k < nsend; k++) begin
      exp = alive && (k < int'(cnt_b));
      if (exp && k < NUM_REGS) model[k] = tx_data[k];
      t = (k >= int'(cnt_b)) ? " R8 beyond count" :
          (k >= NUM_REGS)    ? " R7 beyond bank"  : " R5 data";
      send_byte(tx_data[k], ack);
      chk(ack == exp, 64'(ack), 64'(exp), {tag, t, " ack"});
      alive = exp;
    end
    if (do_stop) begin
      bus_stop();
      check_regs(tag);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < NUM_REGS; i++)
      model[i] = (i == 0) ? 8'h06 : (i == 1) ? 8'hFF : (i == 2) ? 8'hFE : 8'h00;
    wclk(5);
    rst = 1'b0;
    wclk(5);
    check_regs("R1 reset");

    tx_data[0] = 8'h11; tx_data[1] = 8'h22; tx_data[2] = 8'h33;
    xfer(8'hD2, 8'h00, 8'd3, 3, 1'b1, "R5 basic");
    tx_data[0] = 8'hEE; tx_data[1] = 8'hDD;
    xfer(8'hD3, 8'h00, 8'd2, 2, 1'b1, "R2 read bit");
    xfer(8'hA4, 8'h00, 8'd2, 2, 1'b1, "R2 wrong address");
    xfer(8'hD2, 8'hFF, 8'd0, 2, 1'b1, "R4 count zero");
    xfer(8'hD2, 8'h5A, 8'd33, 1, 1'b1, "R4 count 33");
    for (int i = 0; i < 40; i++) tx_data[i] = 8'(8'h40 + i);
    xfer(8'hD2, 8'h00, 8'd32, 9, 1'b1, "R4 count 32");
    tx_data[0] = 8'hC1; tx_data[1] = 8'hC2;
    xfer(8'hD2, 8'h00, 8'd5, 2, 1'b1, "R6 early stop");
    for (int i = 0; i < 10; i++) tx_data[i] = 8'(8'h90 + i);
    xfer(8'hD2, 8'h00, 8'd10, 10, 1'b1, "R7 past bank");
    tx_data[0] = 8'h01; tx_data[1] = 8'h02; tx_data[2] = 8'h03;
    xfer(8'hD2, 8'h00, 8'd2, 3, 1'b1, "R8 past count");
    tx_data[0] = 8'h06; tx_data[1] = 8'hFF; tx_data[2] = 8'hFE; tx_data[3] = 8'h00;
    tx_data[4] = 8'hA4;
    xfer(8'hD2, 8'h00, 8'd5, 5, 1'b1, "R9 select A4");
    tx_data[4] = 8'h58;
    xfer(8'hD2, 8'h00, 8'd5, 5, 1'b1, "R9 select 58");
    tx_data[0] = 8'h77;
    xfer(8'hD2, 8'h00, 8'd4, 1, 1'b0, "R11 first half");
    tx_data[0] = 8'h88; tx_data[1] = 8'h99;
    xfer(8'hD2, 8'h00, 8'd2, 2, 1'b1, "R11 restart");

    for (int it = 0; it < 40; it++) begin
      logic [7:0] a, c;
      int n;
      a = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'hD2;
      c = 8'($urandom_range(0, 12));
      n = $urandom_range(0, int'(c) + 1);
      for (int k = 0; k < 16; k++) tx_data[k] = 8'($urandom);
      xfer(a, 8'($urandom), c, n, 1'b1, "R5 random");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R5 actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule